// File: doc/BRIEF.md
# Vectored Trap Entry and Return Sequencer

This block carries out, one byte at a time, the memory traffic that a segmented 16-bit processor needs to enter a software trap and to return from one. On entry it saves the status word and the return segment and offset on a stack that grows downward. It then loads a new code segment and offset from a table of four-byte entries at the bottom of the address space. On return it restores the saved words from the stack. The core's decode logic pulses one of three start strobes: a typed trap with an 8-bit type, a trap that fires only on overflow, or a return. It also presents the current code segment, offset, stack segment, stack pointer and status word.

The sequencer drives a byte-wide memory port with a ready handshake. Each access finishes on a clock edge where both the request and ready are high. When it finishes, the block pulses `done`. The updated registers are then on its outputs, and they stay there until the next start.

Top module: `vts_top`

## Requirements
- R1: A typed entry leaves the stack pointer 6 lower. The word at stack offsets SP-2/SP-1 holds the original status word, SP-4/SP-3 holds the original code segment and SP-6/SP-5 holds the original offset. Each word is stored low byte at the lower address.
- R2: After a typed entry with type t, the offset output equals the bytes at physical addresses 4t (low) and 4t+1 (high). The code segment output equals the bytes at 4t+2 (low) and 4t+3 (high).
- R3: Every stack address is the stack segment times 16 plus the 16-bit offset, truncated to 20 bits. Offsets wrap modulo 2^16 and the sum wraps modulo 2^20. Table addresses use segment 0.
- R4: After an entry, bits 9 and 8 of the status output are 0. All other bits keep their value from before the entry.
- R5: An entry makes exactly ten byte accesses, in this order: status high write, status low write, code segment high write, code segment low write, table reads of 4t+2 then 4t+3, offset high write, offset low write, table reads of 4t then 4t+1.
- R6: A return makes six byte reads at stack offsets SP to SP+5, in ascending order. The offset is taken from SP/SP+1, the code segment from SP+2/SP+3 and the status word from SP+4/SP+5, each low byte first. The stack pointer ends 6 higher.
- R7: With status bit 11 set, the overflow start performs a type-4 entry. With bit 11 clear, it makes no memory access and raises `done` in the cycle after the strobe, with every output equal to the inputs.
- R8: While `mem_ready` is low, the request, address, write enable and write data stay unchanged. Stalls never change the final register values or the memory image.
- R9: `done` is high for exactly one cycle per operation. The outputs hold their values until the next start.
- R10: When more than one strobe is high in the same idle cycle, the typed strobe wins over the overflow strobe, and the overflow strobe wins over the return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_int | input | 1 | Start a typed trap entry |
| int_type | input | 8 | Trap type number |
| start_ovf | input | 1 | Start a trap that fires only on overflow (type 4) |
| start_ret | input | 1 | Start a trap return |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current offset (address of the following instruction) |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Current stack pointer |
| flags_i | input | 16 | Current status word |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid while ready is high |
| mem_ready | input | 1 | Access completes on this edge |
| cs_o | output | 16 | Resulting code segment |
| ip_o | output | 16 | Resulting offset |
| sp_o | output | 16 | Resulting stack pointer |
| flags_o | output | 16 | Resulting status word |
| done | output | 1 | One-cycle completion pulse |

## Verification
All 256 type numbers are swept. Each entry uses different segment, offset, stack pointer and status values. This separates the low and high table bytes, the word order on the stack and the masking of status bits. Every other entry runs against a ready line that a pseudo-random pattern holds low, so a result that depends on stall timing shows up against the unstalled runs. A stack segment near the top of memory makes the 20-bit sum wrap. A round trip confirms that a return restores exactly what an entry saved. The overflow strobe is run with the flag set and clear, and with competing strobes, to tell a skipped operation from a return or an entry.

// File: rtl/vts_pkg.sv
package vts_pkg;
  localparam int WORD_W = 16;
  localparam int STEP_W = 4;
  localparam int FL_TF  = 8;
  localparam int FL_IF  = 9;
  localparam int FL_OF  = 11;

  typedef enum logic [1:0] {SEL_FL, SEL_CS, SEL_IP} reg_sel_e;
  typedef enum logic [1:0] {MODE_ENTRY, MODE_RET, MODE_SKIP} mode_e;
  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  // One byte access: direction, address base, signed/unsigned offset, target word, byte lane
  typedef struct packed {
    logic       wr;
    logic       tbl;
    logic [3:0] off;
    reg_sel_e   sel;
    logic       hi;
  } uop_t;
endpackage

// File: rtl/vts_uop_dec.sv
module vts_uop_dec
  import vts_pkg::*;
(
  input  logic              is_ret,
  input  logic [STEP_W-1:0] step,
  output uop_t              uop,
  output logic              last
);
  localparam int ENTRY_LAST = 9;
  localparam int RET_LAST   = 5;

  always_comb begin
    uop  = '0;
    last = 1'b0;
    if (is_ret) begin
      uop.wr  = 1'b0;
      uop.tbl = 1'b0;
      uop.off = step;
      uop.hi  = step[0];
      unique case (step[2:1])
        2'd0:    uop.sel = SEL_IP;
        2'd1:    uop.sel = SEL_CS;
        default: uop.sel = SEL_FL;
      endcase
      last = (step == STEP_W'(RET_LAST));
    end else begin
      unique case (step)
        4'd0: uop = '{wr:1'b1, tbl:1'b0, off:4'hF, sel:SEL_FL, hi:1'b1};
        4'd1: uop = '{wr:1'b1, tbl:1'b0, off:4'hE, sel:SEL_FL, hi:1'b0};
        4'd2: uop = '{wr:1'b1, tbl:1'b0, off:4'hD, sel:SEL_CS, hi:1'b1};
        4'd3: uop = '{wr:1'b1, tbl:1'b0, off:4'hC, sel:SEL_CS, hi:1'b0};
        4'd4: uop = '{wr:1'b0, tbl:1'b1, off:4'h2, sel:SEL_CS, hi:1'b0};
        4'd5: uop = '{wr:1'b0, tbl:1'b1, off:4'h3, sel:SEL_CS, hi:1'b1};
        4'd6: uop = '{wr:1'b1, tbl:1'b0, off:4'hB, sel:SEL_IP, hi:1'b1};
        4'd7: uop = '{wr:1'b1, tbl:1'b0, off:4'hA, sel:SEL_IP, hi:1'b0};
        4'd8: uop = '{wr:1'b0, tbl:1'b1, off:4'h0, sel:SEL_IP, hi:1'b0};
        default: uop = '{wr:1'b0, tbl:1'b1, off:4'h1, sel:SEL_IP, hi:1'b1};
      endcase
      last = (step == STEP_W'(ENTRY_LAST));
    end
  end
endmodule

// File: rtl/vts_agu.sv
module vts_agu
  import vts_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int TYPE_W    = 8
) (
  input  uop_t              uop,
  input  logic [WORD_W-1:0] ss,
  input  logic [WORD_W-1:0] sp0,
  input  logic [TYPE_W-1:0] vtype,
  output logic [ADDR_W-1:0] addr
);
  logic [WORD_W-1:0] off_w;
  logic [WORD_W-1:0] seg_w;
  logic [ADDR_W-1:0] seg_ext;

  always_comb begin
    if (uop.tbl) begin
      seg_w = '0;
      off_w = WORD_W'({vtype, 2'b00}) + WORD_W'(uop.off[1:0]);
    end else begin
      seg_w = ss;
      off_w = sp0 + {{(WORD_W-4){uop.off[3]}}, uop.off};
    end
    seg_ext = ADDR_W'(seg_w) << SEG_SHIFT;
    addr    = seg_ext + ADDR_W'(off_w);
  end
endmodule

// File: rtl/vts_top.sv
module vts_top
  import vts_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter int TYPE_W    = 8,
  parameter int OVF_TYPE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_int,
  input  logic [TYPE_W-1:0] int_type,
  input  logic              start_ovf,
  input  logic              start_ret,
  input  logic [15:0]       cs_i,
  input  logic [15:0]       ip_i,
  input  logic [15:0]       ss_i,
  input  logic [15:0]       sp_i,
  input  logic [15:0]       flags_i,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic [15:0]       cs_o,
  output logic [15:0]       ip_o,
  output logic [15:0]       sp_o,
  output logic [15:0]       flags_o,
  output logic              done
);
  localparam logic [WORD_W-1:0] FRAME_BYTES = WORD_W'(6);

  state_e            state_q;
  mode_e             mode_q;
  logic [STEP_W-1:0] step_q;
  logic [TYPE_W-1:0] vtype_q;
  logic [WORD_W-1:0] ss_q, sp0_q, sp_q, cs_q, ip_q, fl_q;
  logic              done_q;

  logic go_int, go_ovf, go_ret, cap, idle_w;
  uop_t uop;
  logic last;
  logic [WORD_W-1:0] wsel;

  assign idle_w = (state_q == ST_IDLE);
  assign go_int = idle_w && start_int;
  assign go_ovf = idle_w && !start_int && start_ovf;
  assign go_ret = idle_w && !start_int && !start_ovf && start_ret;
  assign cap    = go_int || go_ovf || go_ret;

  vts_uop_dec u_dec (
    .is_ret (mode_q == MODE_RET),
    .step   (step_q),
    .uop    (uop),
    .last   (last)
  );

  vts_agu #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .TYPE_W    (TYPE_W)
  ) u_agu (
    .uop   (uop),
    .ss    (ss_q),
    .sp0   (sp0_q),
    .vtype (vtype_q),
    .addr  (mem_addr)
  );

  always_comb begin
    unique case (uop.sel)
      SEL_FL:  wsel = fl_q;
      SEL_CS:  wsel = cs_q;
      default: wsel = ip_q;
    endcase
  end

  assign mem_req   = (state_q == ST_RUN);
  assign mem_we    = mem_req && uop.wr;
  assign mem_wdata = uop.hi ? wsel[15:8] : wsel[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ENTRY;
      step_q  <= '0;
      vtype_q <= '0;
      ss_q    <= '0;
      sp0_q   <= '0;
      sp_q    <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      fl_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cap) begin
        ss_q   <= ss_i;
        sp0_q  <= sp_i;
        sp_q   <= sp_i;
        cs_q   <= cs_i;
        ip_q   <= ip_i;
        fl_q   <= flags_i;
        step_q <= '0;
      end
      if (go_int) begin
        vtype_q <= int_type;
        mode_q  <= MODE_ENTRY;
        state_q <= ST_RUN;
      end else if (go_ovf) begin
        vtype_q <= TYPE_W'(OVF_TYPE);
        if (flags_i[FL_OF]) begin
          mode_q  <= MODE_ENTRY;
          state_q <= ST_RUN;
        end else begin
          mode_q <= MODE_SKIP;
          done_q <= 1'b1;
        end
      end else if (go_ret) begin
        mode_q  <= MODE_RET;
        state_q <= ST_RUN;
      end

      if (state_q == ST_RUN && mem_ready) begin
        if (!uop.wr) begin
          unique case (uop.sel)
            SEL_FL: if (uop.hi) fl_q[15:8] <= mem_rdata; else fl_q[7:0] <= mem_rdata;
            SEL_CS: if (uop.hi) cs_q[15:8] <= mem_rdata; else cs_q[7:0] <= mem_rdata;
            default: if (uop.hi) ip_q[15:8] <= mem_rdata; else ip_q[7:0] <= mem_rdata;
          endcase
        end else if (uop.sel == SEL_FL && !uop.hi) begin
          fl_q[FL_IF] <= 1'b0;
          fl_q[FL_TF] <= 1'b0;
        end
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          sp_q    <= (mode_q == MODE_RET) ? sp0_q + FRAME_BYTES : sp0_q - FRAME_BYTES;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = sp_q;
  assign flags_o = fl_q;
  assign done    = done_q;
endmodule

// File: rtl/vts_chk.sv
module vts_chk
  import vts_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              idle,
  input logic              start_int,
  input logic              start_ovf,
  input logic              ovf_flag,
  input mode_e             mode,
  input logic [1:0]        mask_bits
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8

  AST_OVF_SKIP: assert property (@(posedge clk) disable iff (rst)
    idle && !start_int && start_ovf && !ovf_flag |=> done && !mem_req); // R7

  AST_ENTRY_MASK: assert property (@(posedge clk) disable iff (rst)
    done && mode == MODE_ENTRY |-> mask_bits == 2'b00); // R4
endmodule

bind vts_top vts_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .idle      (idle_w),
  .start_int (start_int),
  .start_ovf (start_ovf),
  .ovf_flag  (flags_i[vts_pkg::FL_OF]),
  .mode      (mode_q),
  .mask_bits ({flags_o[vts_pkg::FL_IF], flags_o[vts_pkg::FL_TF]})
);

// File: tb/vts_top_tb_top.sv
`timescale 1ns/1ps
module vts_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        start_int = 0, start_ovf = 0, start_ret = 0;
  logic [7:0]  int_type = 0;
  logic [15:0] cs_i = 0, ip_i = 0, ss_i = 0, sp_i = 0, flags_i = 0;
  logic        mem_req, mem_we, mem_ready, done;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] cs_o, ip_o, sp_o, flags_o;

  vts_top dut_i (.*);

  logic [7:0]  mem [0:4095];
  logic [19:0] tr_a [0:15];
  logic        tr_w [0:15];
  logic [7:0]  tr_d [0:15];
  int          tr_n = 0;
  logic        oob = 0;
  logic        stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  int n_chk = 0, n_err = 0, cyc = 0, wait_cyc = 0;

  assign mem_rdata = mem[mem_addr[11:0]];
  assign mem_ready = !stall_en || lfsr[0];

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (tr_n < 16) begin
        tr_a[tr_n] <= mem_addr; tr_w[tr_n] <= mem_we; tr_d[tr_n] <= mem_wdata;
      end
      tr_n <= tr_n + 1;
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      if (mem_addr[19:12] != 0) oob <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    return 20'({4'b0, seg} << 4) + 20'(off);
  endfunction

  function automatic logic [7:0] tbl(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic si, input logic so, input logic sr, input logic [7:0] t,
                        input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] ss,
                        input logic [15:0] sp, input logic [15:0] fl);
    @(negedge clk);
    tr_n = 0;
    int_type = t; cs_i = cs; ip_i = ip; ss_i = ss; sp_i = sp; flags_i = fl;
    start_int = si; start_ovf = so; start_ret = sr;
    wait_cyc = 0;
    @(negedge clk);
    start_int = 0; start_ovf = 0; start_ret = 0;
    while (!done && wait_cyc < 400) begin
      @(negedge clk);
      wait_cyc++;
    end
  endtask

  task automatic check_entry(input string tag, input logic [7:0] t, input logic [15:0] cs,
                             input logic [15:0] ip, input logic [15:0] ss,
                             input logic [15:0] sp, input logic [15:0] fl);
    logic [19:0] ea [0:9];
    logic        ew [0:9];
    logic [7:0]  ed [0:9];
    logic [19:0] tb;
    logic        bad;
    logic [47:0] img;
    tb = 20'({t, 2'b00});
    ea[0] = phys(ss, sp - 1); ew[0] = 1; ed[0] = fl[15:8];
    ea[1] = phys(ss, sp - 2); ew[1] = 1; ed[1] = fl[7:0];
    ea[2] = phys(ss, sp - 3); ew[2] = 1; ed[2] = cs[15:8];
    ea[3] = phys(ss, sp - 4); ew[3] = 1; ed[3] = cs[7:0];
    ea[4] = tb + 2;           ew[4] = 0; ed[4] = 0;
    ea[5] = tb + 3;           ew[5] = 0; ed[5] = 0;
    ea[6] = phys(ss, sp - 5); ew[6] = 1; ed[6] = ip[15:8];
    ea[7] = phys(ss, sp - 6); ew[7] = 1; ed[7] = ip[7:0];
    ea[8] = tb;               ew[8] = 0; ed[8] = 0;
    ea[9] = tb + 1;           ew[9] = 0; ed[9] = 0;
    chk("R9", {tag, " done seen"}, 64'(done), 64'd1);
    chk("R5", {tag, " access count"}, 64'(tr_n), 64'd10);
    bad = oob;
    for (int k = 0; k < 10; k++)
      if (tr_a[k] !== ea[k] || tr_w[k] !== ew[k] || (ew[k] && tr_d[k] !== ed[k])) bad = 1;
    chk("R5", {tag, " access order/address (R3)"}, 64'(bad), 64'd0);
    chk("R2", {tag, " ip"}, 64'(ip_o), 64'({tbl(int'(tb) + 1), tbl(int'(tb))}));
    chk("R2", {tag, " cs"}, 64'(cs_o), 64'({tbl(int'(tb) + 3), tbl(int'(tb) + 2)}));
    chk("R1", {tag, " sp"}, 64'(sp_o), 64'(16'(sp - 6)));
    chk("R4", {tag, " flags"}, 64'(flags_o), 64'(fl & 16'hFCFF));
    for (int k = 1; k <= 6; k++) img = {img[39:0], mem[phys(ss, 16'(sp - 16'(k)))[11:0]]};
    chk("R1", {tag, " stack image"}, 64'(img), 64'({fl, cs, ip}));
  endtask

  initial begin
    logic [15:0] cs, ip, sp, fl, sv_cs, sv_ip, sv_fl, sv_sp;
    for (int i = 0; i < 4096; i++) mem[i] = tbl(i);
    repeat (3) @(negedge clk);
    chk("R9", "reset done", 64'(done), 64'd0);
    chk("R9", "reset req", 64'(mem_req), 64'd0);
    rst = 0;

    // Sweep every type number, alternating stall patterns (R8)
    for (int n = 0; n < 256; n++) begin
      cs = 16'(n * 263 + 5); ip = 16'(n * 91 + 16'h1234);
      sp = 16'h0100 + 16'((n % 8) * 2); fl = 16'(n * 16'h1357) | 16'h0300;
      stall_en = n[0];
      launch(1, 0, 0, 8'(n), cs, ip, 16'h0080, sp, fl);
      check_entry($sformatf("R8 sweep t=%0d", n), 8'(n), cs, ip, 16'h0080, sp, fl);
    end

    // 20-bit wrap of segment*16+offset (R3)
    stall_en = 0;
    launch(1, 0, 0, 8'd7, 16'hBEEF, 16'h4321, 16'hFFFF, 16'h0900, 16'h0F55);
    check_entry("R3 wrap", 8'd7, 16'hBEEF, 16'h4321, 16'hFFFF, 16'h0900, 16'h0F55);

    // Hold after done (R9)
    sv_cs = cs_o; sv_ip = ip_o;
    @(negedge clk);
    chk("R9", "done falls", 64'(done), 64'd0);
    repeat (5) @(negedge clk);
    chk("R9", "outputs hold", 64'({cs_o, ip_o}), 64'({sv_cs, sv_ip}));

    // Round trip: entry then return (R6)
    launch(1, 0, 0, 8'h21, 16'h1111, 16'h2222, 16'h0080, 16'h0200, 16'h0ACE);
    check_entry("R6 pre", 8'h21, 16'h1111, 16'h2222, 16'h0080, 16'h0200, 16'h0ACE);
    sv_sp = sp_o;
    stall_en = 1;
    launch(0, 0, 1, 8'h00, 16'h9999, 16'h8888, 16'h0080, sv_sp, 16'h0000);
    chk("R6", "ret ip", 64'(ip_o), 64'h2222);
    chk("R6", "ret cs", 64'(cs_o), 64'h1111);
    chk("R6", "ret flags", 64'(flags_o), 64'h0ACE);
    chk("R6", "ret sp", 64'(sp_o), 64'h0200);
    chk("R6", "ret count", 64'(tr_n), 64'd6);
    begin
      logic bad = oob;
      for (int k = 0; k < 6; k++)
        if (tr_w[k] !== 1'b0 || tr_a[k] !== phys(16'h0080, 16'(sv_sp + 16'(k)))) bad = 1;
      chk("R6", "ret addresses", 64'(bad), 64'd0);
    end

    // Overflow start, flag set: type-4 entry (R7)
    stall_en = 0;
    launch(0, 1, 0, 8'hEE, 16'h3030, 16'h4040, 16'h0080, 16'h0300, 16'h0B01);
    check_entry("R7 of=1", 8'd4, 16'h3030, 16'h4040, 16'h0080, 16'h0300, 16'h0B01);

    // Overflow start, flag clear: nothing happens (R7)
    launch(0, 1, 0, 8'hEE, 16'h5050, 16'h6060, 16'h0080, 16'h0300, 16'h0301);
    chk("R7", "skip latency", 64'(wait_cyc), 64'd0);
    chk("R7", "skip no access", 64'(tr_n), 64'd0);
    chk("R7", "skip outputs", 64'({cs_o, ip_o, sp_o, flags_o}),
        64'({16'h5050, 16'h6060, 16'h0300, 16'h0301}));

    // Priority (R10)
    launch(1, 0, 1, 8'h10, 16'h7070, 16'h0A0A, 16'h0080, 16'h0120, 16'h0000);
    check_entry("R10 int+ret", 8'h10, 16'h7070, 16'h0A0A, 16'h0080, 16'h0120, 16'h0000);
    launch(0, 1, 1, 8'h00, 16'h1212, 16'h3434, 16'h0080, 16'h0140, 16'h0002);
    chk("R10", "ovf+ret skip", 64'({tr_n, sp_o}), 64'({32'd0, 16'h0140}));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule